// File: doc/BRIEF.md
# Per-Application Memory Profiler and Classifier

This block keeps four event counters per application over a fixed, programmable profiling window. The counters track retired instructions, last-level-cache misses, memory accesses and row-buffer hits. Each application drives its own single-bit pulse lines, and the channel controllers drive the access and hit lines tagged by application. When a window closes, the counts are frozen into a snapshot and the live counters restart from zero on the same edge. A single shared sequential divider then works through the applications one at a time. For each one it derives two ratios: misses per thousand instructions, and the percentage of accesses that found their row already open.

Each application then lands in one of three groups. A miss-intensity test comes first. Only applications that reach the intensity threshold go on to a locality test against the hit-percentage threshold. A separate flag marks applications whose intensity falls under a third, lower threshold, so that a request scheduler can favour them. The results of one window are published together. They stay readable through a per-application read port for the whole of the following window, which is where system software picks them up to make its channel decisions.

Top module: `mem_app_profiler`

## Requirements
- R1: The `boundary` output is high for one cycle every L cycles, where L is the interval length written to configuration address 0.
- R2: Per application, events pulsed on the four event inputs are counted. On the edge that closes a window the counts, including that cycle's events, are captured and the live counters restart from zero.
- R3: The intensity metric equals floor(misses*1000/instructions), saturated to 65535. It is 0 when the window saw no retired instruction.
- R4: The hit percentage equals floor(hits*100/accesses). It is 0 when the window saw no access.
- R5: An application whose intensity is below the intensity threshold (configuration address 1) gets group code 2'b00, whatever its hit percentage.
- R6: An application whose intensity is at or above that threshold gets 2'b01 when its hit percentage is below the locality threshold (configuration address 2), and 2'b10 otherwise. The code 2'b11 never appears.
- R7: The priority flag is set exactly when the intensity is below the very-low threshold (configuration address 3).
- R8: `done` drops on the edge that closes a window. It rises once every application of the finished window has been classified. Published results change only at that moment and then hold until the next publication.
- R9: `rd_data` returns the published record of the application selected by `rd_app`: intensity in bits 15:0, hit percentage in bits 23:16, group code in bits 25:24, priority flag in bit 26, and zeros above.
- R10: While reset is asserted and straight after it, `done`, `boundary` and `rd_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_retire | input | NUM_APPS | Per-application instruction retire pulse |
| ev_llc_miss | input | NUM_APPS | Per-application last-level-cache miss pulse |
| ev_mem_access | input | NUM_APPS | Per-application memory access pulse from a channel controller |
| ev_row_hit | input | NUM_APPS | Per-application open-row hit pulse from a channel controller |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select: 0 length, 1 intensity threshold, 2 locality threshold, 3 very-low threshold |
| cfg_wdata | input | CFG_W | Configuration write value |
| rd_app | input | APP_W | Application whose published record is read |
| rd_data | output | 32 | Published record of the selected application |
| boundary | output | 1 | High in the last cycle of each window |
| done | output | 1 | Published results of the previous window are valid |

## Verification
The assertions take for granted that a row-hit pulse for an application only arrives together with an access pulse for the same application. They also assume the thresholds are not rewritten while a window's results are being computed or held. The hit-percentage range check and the classification checks depend on these two points. The stimulus writes the configuration once, before the first window closes. It shapes every window so that the hit pulses fall in a prefix of the access pulses, and so that each count stays under the window length. That window length is long enough for the divider to finish every application before the next boundary.

// File: rtl/mem_prof_pkg.sv
package mem_prof_pkg;

  localparam int MPKI_SCALE = 1000;
  localparam int PCT_SCALE  = 100;

  localparam logic [1:0] CFG_LEN      = 2'd0;
  localparam logic [1:0] CFG_INT_THR  = 2'd1;
  localparam logic [1:0] CFG_LOC_THR  = 2'd2;
  localparam logic [1:0] CFG_VLOW_THR = 2'd3;

  typedef enum logic [1:0] {
    GRP_LOW       = 2'b00,
    GRP_HI_LOWLOC = 2'b01,
    GRP_HI_HILOC  = 2'b10
  } grp_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_MPKI,
    SQ_MPKI_W,
    SQ_PCT,
    SQ_PCT_W,
    SQ_STORE,
    SQ_PUB
  } seq_e;

endpackage

// File: rtl/mprof_event_bank.sv
module mprof_event_bank #(
  parameter int NUM_APPS = 4,
  parameter int CNT_W    = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               close_win,
  input  logic [NUM_APPS-1:0]                ev_retire,
  input  logic [NUM_APPS-1:0]                ev_miss,
  input  logic [NUM_APPS-1:0]                ev_access,
  input  logic [NUM_APPS-1:0]                ev_hit,
  output logic [NUM_APPS-1:0][CNT_W-1:0]     snap_retire,
  output logic [NUM_APPS-1:0][CNT_W-1:0]     snap_miss,
  output logic [NUM_APPS-1:0][CNT_W-1:0]     snap_access,
  output logic [NUM_APPS-1:0][CNT_W-1:0]     snap_hit
);

  localparam int NUM_EV = 4;

  logic [NUM_EV-1:0][NUM_APPS-1:0]             ev_all;
  logic [NUM_EV-1:0][NUM_APPS-1:0][CNT_W-1:0]  cnt_q, cnt_n, snap_q;

  assign ev_all = {ev_hit, ev_access, ev_miss, ev_retire};

  for (genvar e = 0; e < NUM_EV; e++) begin : g_ev
    for (genvar a = 0; a < NUM_APPS; a++) begin : g_app
      // saturating increment
      always_comb begin
        cnt_n[e][a] = cnt_q[e][a];
        if (ev_all[e][a] && (cnt_q[e][a] != {CNT_W{1'b1}}))
          cnt_n[e][a] = cnt_q[e][a] + CNT_W'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q[e][a]  <= '0;
          snap_q[e][a] <= '0;
        end else if (close_win) begin
          snap_q[e][a] <= cnt_n[e][a];
          cnt_q[e][a]  <= '0;
        end else begin
          cnt_q[e][a]  <= cnt_n[e][a];
        end
      end
    end
  end

  assign snap_retire = snap_q[0];
  assign snap_miss   = snap_q[1];
  assign snap_access = snap_q[2];
  assign snap_hit    = snap_q[3];

endmodule

// File: rtl/mprof_divider.sv
module mprof_divider #(
  parameter int NUM_W = 26,
  parameter int DEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             valid,
  output logic [NUM_W-1:0] quot
);

  localparam int CNT_BW = $clog2(NUM_W + 1);

  logic [DEN_W-1:0]  rem_q, rem_n, den_q, den_n;
  logic [NUM_W-1:0]  quo_q, quo_n;
  logic [CNT_BW-1:0] cnt_q, cnt_n;
  logic              busy_q, busy_n, valid_q, valid_n;
  logic [DEN_W:0]    rem_sh;
  logic              ge;

  // one restoring step per cycle, quotient bits shift in from the right
  always_comb begin
    rem_sh  = {rem_q, quo_q[NUM_W-1]};
    ge      = rem_sh >= {1'b0, den_q};
    rem_n   = rem_q;
    quo_n   = quo_q;
    den_n   = den_q;
    cnt_n   = cnt_q;
    busy_n  = busy_q;
    valid_n = 1'b0;
    if (start) begin
      rem_n  = '0;
      quo_n  = num;
      den_n  = den;
      cnt_n  = CNT_BW'(NUM_W);
      busy_n = 1'b1;
    end else if (busy_q) begin
      rem_n = ge ? DEN_W'(rem_sh - {1'b0, den_q}) : rem_sh[DEN_W-1:0];
      quo_n = {quo_q[NUM_W-2:0], ge};
      cnt_n = cnt_q - CNT_BW'(1);
      if (cnt_q == CNT_BW'(1)) begin
        busy_n  = 1'b0;
        valid_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q   <= '0;
      quo_q   <= '0;
      den_q   <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      rem_q   <= rem_n;
      quo_q   <= quo_n;
      den_q   <= den_n;
      cnt_q   <= cnt_n;
      busy_q  <= busy_n;
      valid_q <= valid_n;
    end
  end

  assign busy  = busy_q;
  assign valid = valid_q;
  assign quot  = quo_q;

endmodule

// File: rtl/mprof_classifier.sv
module mprof_classifier
  import mem_prof_pkg::*;
#(
  parameter int MPKI_W = 16,
  parameter int PCT_W  = 8
) (
  input  logic [MPKI_W-1:0] mpki,
  input  logic [PCT_W-1:0]  pct,
  input  logic [MPKI_W-1:0] int_thr,
  input  logic [PCT_W-1:0]  loc_thr,
  input  logic [MPKI_W-1:0] vlow_thr,
  output grp_e              grp,
  output logic              vlow
);

  // intensity decides first; locality only splits the intensive set
  always_comb begin
    if (mpki < int_thr)
      grp = GRP_LOW;
    else if (pct < loc_thr)
      grp = GRP_HI_LOWLOC;
    else
      grp = GRP_HI_HILOC;
    vlow = mpki < vlow_thr;
  end

endmodule

// File: rtl/mem_app_profiler.sv
module mem_app_profiler
  import mem_prof_pkg::*;
#(
  parameter int NUM_APPS = 4,
  parameter int CNT_W    = 16,
  parameter int CFG_W    = 16,
  parameter int PCT_W    = 8,
  localparam int APP_W   = (NUM_APPS > 1) ? $clog2(NUM_APPS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_APPS-1:0] ev_retire,
  input  logic [NUM_APPS-1:0] ev_llc_miss,
  input  logic [NUM_APPS-1:0] ev_mem_access,
  input  logic [NUM_APPS-1:0] ev_row_hit,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_addr,
  input  logic [CFG_W-1:0]    cfg_wdata,
  input  logic [APP_W-1:0]    rd_app,
  output logic [31:0]         rd_data,
  output logic                boundary,
  output logic                done
);

  localparam int MPKI_W  = CFG_W;
  localparam int NUM_W   = CNT_W + 10;
  localparam int REC_W   = 1 + 2 + PCT_W + MPKI_W;
  localparam logic [CFG_W-1:0] LEN_RST = CFG_W'(1024);

  // ---------------- configuration ----------------
  logic [CFG_W-1:0]  len_q, int_thr_q, vlow_thr_q;
  logic [PCT_W-1:0]  loc_thr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q      <= LEN_RST;
      int_thr_q  <= CFG_W'(10);
      loc_thr_q  <= PCT_W'(50);
      vlow_thr_q <= CFG_W'(1);
    end else if (cfg_we) begin
      case (cfg_addr)
        CFG_LEN:     len_q      <= cfg_wdata;
        CFG_INT_THR: int_thr_q  <= cfg_wdata;
        CFG_LOC_THR: loc_thr_q  <= cfg_wdata[PCT_W-1:0];
        default:     vlow_thr_q <= cfg_wdata;
      endcase
    end
  end

  // ---------------- interval timer ----------------
  logic [CFG_W-1:0] cyc_q, cyc_n;
  logic             tick;

  always_comb begin
    tick  = cyc_q >= (len_q - CFG_W'(1));
    cyc_n = tick ? '0 : cyc_q + CFG_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_q <= '0;
    else        cyc_q <= cyc_n;
  end

  assign boundary = tick;

  // ---------------- counters ----------------
  logic [NUM_APPS-1:0][CNT_W-1:0] s_ret, s_miss, s_acc, s_hit;

  mprof_event_bank #(.NUM_APPS(NUM_APPS), .CNT_W(CNT_W)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .close_win   (tick),
    .ev_retire   (ev_retire),
    .ev_miss     (ev_llc_miss),
    .ev_access   (ev_mem_access),
    .ev_hit      (ev_row_hit),
    .snap_retire (s_ret),
    .snap_miss   (s_miss),
    .snap_access (s_acc),
    .snap_hit    (s_hit)
  );

  // ---------------- shared divider ----------------
  logic             div_start, div_busy, div_valid;
  logic [NUM_W-1:0] div_num, div_quot;
  logic [CNT_W-1:0] div_den;

  mprof_divider #(.NUM_W(NUM_W), .DEN_W(CNT_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .num   (div_num),
    .den   (div_den),
    .busy  (div_busy),
    .valid (div_valid),
    .quot  (div_quot)
  );

  // ---------------- sequencer state ----------------
  seq_e                            st_q, st_n;
  logic [APP_W-1:0]                idx_q, idx_n;
  logic [MPKI_W-1:0]               cur_mpki_q, cur_mpki_n;
  logic [PCT_W-1:0]                cur_pct_q, cur_pct_n;
  logic [NUM_APPS-1:0][REC_W-1:0]  wk_q, wk_n, pub_q, pub_n;
  logic                            done_q, done_n;
  grp_e                            cls_grp;
  logic                            cls_vlow;
  logic [MPKI_W-1:0]               quot_mpki;
  logic [PCT_W-1:0]                quot_pct;

  mprof_classifier #(.MPKI_W(MPKI_W), .PCT_W(PCT_W)) u_cls (
    .mpki     (cur_mpki_q),
    .pct      (cur_pct_q),
    .int_thr  (int_thr_q),
    .loc_thr  (loc_thr_q),
    .vlow_thr (vlow_thr_q),
    .grp      (cls_grp),
    .vlow     (cls_vlow)
  );

  // saturate the wide quotient into each metric field
  assign quot_mpki = (|div_quot[NUM_W-1:MPKI_W]) ? {MPKI_W{1'b1}} : div_quot[MPKI_W-1:0];
  assign quot_pct  = (|div_quot[NUM_W-1:PCT_W])  ? {PCT_W{1'b1}}  : div_quot[PCT_W-1:0];

  always_comb begin
    st_n       = st_q;
    idx_n      = idx_q;
    cur_mpki_n = cur_mpki_q;
    cur_pct_n  = cur_pct_q;
    wk_n       = wk_q;
    pub_n      = pub_q;
    done_n     = done_q;
    div_start  = 1'b0;
    div_num    = '0;
    div_den    = '0;
    if (tick) begin
      st_n   = SQ_MPKI;
      idx_n  = '0;
      done_n = 1'b0;
    end else begin
      case (st_q)
        SQ_MPKI: begin
          if (s_ret[idx_q] == '0) begin
            cur_mpki_n = '0;
            st_n       = SQ_PCT;
          end else begin
            div_start = 1'b1;
            div_num   = NUM_W'(s_miss[idx_q]) * NUM_W'(MPKI_SCALE);
            div_den   = s_ret[idx_q];
            st_n      = SQ_MPKI_W;
          end
        end
        SQ_MPKI_W: begin
          if (div_valid) begin
            cur_mpki_n = quot_mpki;
            st_n       = SQ_PCT;
          end
        end
        SQ_PCT: begin
          if (s_acc[idx_q] == '0) begin
            cur_pct_n = '0;
            st_n      = SQ_STORE;
          end else begin
            div_start = 1'b1;
            div_num   = NUM_W'(s_hit[idx_q]) * NUM_W'(PCT_SCALE);
            div_den   = s_acc[idx_q];
            st_n      = SQ_PCT_W;
          end
        end
        SQ_PCT_W: begin
          if (div_valid) begin
            cur_pct_n = quot_pct;
            st_n      = SQ_STORE;
          end
        end
        SQ_STORE: begin
          wk_n[idx_q] = {cls_vlow, cls_grp, cur_pct_q, cur_mpki_q};
          if (idx_q == APP_W'(NUM_APPS - 1)) begin
            st_n = SQ_PUB;
          end else begin
            idx_n = idx_q + APP_W'(1);
            st_n  = SQ_MPKI;
          end
        end
        SQ_PUB: begin
          pub_n  = wk_q;
          done_n = 1'b1;
          st_n   = SQ_IDLE;
        end
        default: st_n = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= SQ_IDLE;
      idx_q      <= '0;
      cur_mpki_q <= '0;
      cur_pct_q  <= '0;
      wk_q       <= '0;
      pub_q      <= '0;
      done_q     <= 1'b0;
    end else begin
      st_q       <= st_n;
      idx_q      <= idx_n;
      cur_mpki_q <= cur_mpki_n;
      cur_pct_q  <= cur_pct_n;
      wk_q       <= wk_n;
      pub_q      <= pub_n;
      done_q     <= done_n;
    end
  end

  assign done    = done_q;
  assign rd_data = (int'(rd_app) < NUM_APPS) ? 32'(pub_q[rd_app]) : 32'd0;

endmodule

// File: rtl/mem_app_profiler_chk.sv
module mem_app_profiler_chk #(
  parameter int NUM_APPS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                boundary,
  input logic                done,
  input logic [31:0]         rd_data,
  input logic [7:0]          rd_sel,
  input logic [NUM_APPS-1:0] ev_mem_access,
  input logic [NUM_APPS-1:0] ev_row_hit
);

  // input assumption: a hit only arrives with an access (R2)
  p_hit_with_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_row_hit & ~ev_mem_access) == '0);

  p_done_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> !done);

  p_done_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !boundary) |=> done);

  p_results_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(done && !boundary) && $stable(rd_sel)) |-> $stable(rd_data));

  p_group_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[25:24] != 2'b11);

  p_pct_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[23:16] <= 8'd100);

  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31:27] == 5'd0);

endmodule

bind mem_app_profiler mem_app_profiler_chk #(.NUM_APPS(NUM_APPS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .boundary      (boundary),
  .done          (done),
  .rd_data       (rd_data),
  .rd_sel        (8'(rd_app)),
  .ev_mem_access (ev_mem_access),
  .ev_row_hit    (ev_row_hit)
);

// File: tb/mem_app_profiler_tb_top.sv
module mem_app_profiler_tb_top;

  localparam int NA    = 4;
  localparam int LEN   = 600;
  localparam int NV    = 14;
  localparam int DRIVE = 300;
  localparam int ITHR  = 200;
  localparam int LTHR  = 50;
  localparam int VTHR  = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NA-1:0] ev_retire, ev_miss, ev_acc, ev_hit;
  logic          cfg_we;
  logic [1:0]    cfg_addr;
  logic [15:0]   cfg_wdata;
  logic [1:0]    rd_app;
  logic [31:0]   rd_data;
  logic          boundary, done;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  int last_b = -1;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mem_app_profiler #(.NUM_APPS(NA)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_retire     (ev_retire),
    .ev_llc_miss   (ev_miss),
    .ev_mem_access (ev_acc),
    .ev_row_hit    (ev_hit),
    .cfg_we        (cfg_we),
    .cfg_addr      (cfg_addr),
    .cfg_wdata     (cfg_wdata),
    .rd_app        (rd_app),
    .rd_data       (rd_data),
    .boundary      (boundary),
    .done          (done)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic bit has_tail(int k);
    return (k % 5) == 3;
  endfunction

  // per-window event counts, with hand-picked corners in the first windows
  task automatic counts(input int k, input int a, output int i, output int m,
                        output int ac, output int h);
    i  = (k*71 + a*29 + 13) % 280;
    m  = (((k*17 + a*5) % 40) * i) / 100;
    ac = (k*23 + a*41 + 7) % 250;
    h  = (((k*13 + a*7) % 11) * ac) / 10;
    if (k == 0 && a == 0) begin i = 0;   m = 0;   ac = 40;  h = 30; end
    if (k == 0 && a == 1) begin i = 120; m = 60;  ac = 0;   h = 0;  end
    if (k == 1 && a == 0) begin i = 100; m = 20;  ac = 100; h = 50; end
    if (k == 1 && a == 1) begin i = 100; m = 19;  ac = 10;  h = 10; end
    if (k == 1 && a == 2) begin i = 1;   m = 250; ac = 200; h = 1;  end
    if (k == 1 && a == 3) begin i = 50;  m = 1;   ac = 7;   h = 3;  end
    if (k == 2 && a == 0) begin i = 100; m = 30;  ac = 100; h = 49; end
    if (k == 2 && a == 1) begin i = 100; m = 1;   ac = 20;  h = 20; end
  endtask

  task automatic cfg_write(input logic [1:0] ad, input int val);
    cfg_we = 1'b1; cfg_addr = ad; cfg_wdata = 16'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drive_window(input int k);
    int i, m, ac, h;
    for (int t = 0; t < DRIVE; t++) begin
      for (int a = 0; a < NA; a++) begin
        counts(k, a, i, m, ac, h);
        ev_retire[a] = t < i;
        ev_miss[a]   = t < m;
        ev_acc[a]    = t < ac;
        ev_hit[a]    = t < h;
      end
      @(negedge clk);
    end
    ev_retire = '0; ev_miss = '0; ev_acc = '0; ev_hit = '0;
  endtask

  task automatic check_window(input int k);
    int i, m, ac, h, e_mpki, e_pct, e_grp, e_vlow;
    check("R8 done low after window close", int'(done), 0);
    while (!done) @(negedge clk);
    for (int a = 0; a < NA; a++) begin
      counts(k, a, i, m, ac, h);
      if (has_tail(k)) i = i + 1;  // boundary-cycle retire belongs to closing window
      e_mpki = (i == 0) ? 0 : (m * 1000) / i;
      if (e_mpki > 65535) e_mpki = 65535;
      e_pct  = (ac == 0) ? 0 : (h * 100) / ac;
      e_grp  = (e_mpki < ITHR) ? 0 : ((e_pct < LTHR) ? 1 : 2);
      e_vlow = (e_mpki < VTHR) ? 1 : 0;
      rd_app = 2'(a);
      #1;
      check("R3 R2 intensity", int'(rd_data[15:0]), e_mpki);
      check("R4 hit percentage", int'(rd_data[23:16]), e_pct);
      check("R5 R6 group code", int'(rd_data[25:24]), e_grp);
      check("R7 priority flag", int'(rd_data[26]), e_vlow);
      check("R9 upper bits zero", int'(rd_data[31:27]), 0);
    end
  endtask

  task automatic wait_boundary();
    while (!boundary) @(negedge clk);
    if (last_b >= 0) check("R1 window length", cyc - last_b, LEN);
    last_b = cyc;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ev_retire = '0; ev_miss = '0; ev_acc = '0; ev_hit = '0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; rd_app = '0;
    repeat (3) @(negedge clk);
    check("R10 done in reset", int'(done), 0);
    check("R10 boundary in reset", int'(boundary), 0);
    check("R10 rd_data in reset", int'(rd_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 done after reset", int'(done), 0);
    check("R10 rd_data after reset", int'(rd_data), 0);
    cfg_write(2'd0, LEN);
    cfg_write(2'd1, ITHR);
    cfg_write(2'd2, LTHR);
    cfg_write(2'd3, VTHR);
    wait_boundary();
    @(negedge clk);
    for (int k = 0; k <= NV; k++) begin
      fork
        begin
          if (k < NV) drive_window(k);
        end
        begin
          if (k > 0) check_window(k - 1);
        end
      join
      wait_boundary();
      if (k < NV && has_tail(k)) ev_retire = '1;
      @(negedge clk);
      ev_retire = '0;
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule